// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a W-bit register (eight bits by default) that can keep its value, shift toward the most significant bit, shift toward the least significant bit, or take a whole word from its parallel port. A two-bit mode input picks the operation. Each shift takes a new bit from one of two serial inputs. The end bits of the register are always visible on two serial outputs, so several copies can be chained into a longer word.

The parallel port is shared between output and input. It is modelled as three signals: a data-out vector, one output-enable bit and a data-in vector. A chip-level pad ring can turn these into a tristate bus. The drivers turn off whenever load mode is selected, so the same pins can carry the new word in. Either of two active-high disable inputs also turns the drivers off. The register still holds, shifts, loads and resets while its drivers are off.

All state changes happen on the rising clock edge, except the reset. The reset is active-low and asynchronous. It overrides both the clock and the mode inputs.

The port carries a word with no flow control, so the usual valid/ready handshake does not fit here. Back-pressure does not exist: data is taken on every clock edge, and the mode pins alone decide what happens to it.

Top module: `ushr_bidir`

## Requirements
- R1: While rst_n is low, the register is zero immediately, without waiting for a clock edge. pad_out, tail_lsb and tail_msb then all read 0.
- R2: With mode 2'b00 (hold), a rising edge leaves the register unchanged, whatever ser_right_in, ser_left_in and pad_in are.
- R3: With mode 2'b01 (shift right), a rising edge moves every bit i to bit i+1, and bit 0 takes ser_right_in.
- R4: With mode 2'b10 (shift left), a rising edge moves every bit i to bit i-1, and bit W-1 takes ser_left_in.
- R5: With mode 2'b11 (load), a rising edge copies pad_in into the register.
- R6: pad_oe is 1 exactly when dis_a is 0, dis_b is 0 and mode is not 2'b11. Otherwise it is 0.
- R7: The register holds, shifts and loads in the same way when pad_oe is 0 because of dis_a or dis_b.
- R8: tail_lsb always equals register bit 0 and tail_msb always equals bit W-1, whatever the disable inputs are. pad_out always carries the register contents.
- R9: Two copies can be chained into a 2W-bit shifter. The lower copy's tail_msb feeds the upper copy's ser_right_in, and the upper copy's tail_lsb feeds the lower copy's ser_left_in. A common mode input then shifts the combined word by one place each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_right_in | input | 1 | Serial bit entering bit 0 on a right shift |
| ser_left_in | input | 1 | Serial bit entering bit W-1 on a left shift |
| dis_a | input | 1 | Output disable, active high |
| dis_b | input | 1 | Output disable, active high |
| pad_in | input | W | Parallel word sampled in load mode |
| pad_out | output | W | Register contents toward the shared pins |
| pad_oe | output | 1 | Drive enable for the shared pins |
| tail_lsb | output | 1 | Register bit 0, always driven |
| tail_msb | output | 1 | Register bit W-1, always driven |

## Verification
The clocked properties assume that mode, ser_right_in, ser_left_in and pad_in are settled around each rising edge. They also assume that rst_n is released away from an edge, so that the first enabled sample follows a clean cleared state. The stimulus changes every input only on the falling clock edge, including the reset release. The one exception is a reset pulse placed in the middle of the high phase. The properties in flight are then disabled by the reset condition, and the bench checks the cleared value before the next rising edge.

// File: rtl/ushr_pkg.sv
package ushr_pkg;
  typedef enum logic [1:0] {
    M_HOLD = 2'b00,
    M_SHR  = 2'b01,
    M_SHL  = 2'b10,
    M_LOAD = 2'b11
  } ushr_mode_e;
endpackage

// File: rtl/ushr_next.sv
module ushr_next
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load_val,
  input  ushr_mode_e   mode,
  input  logic         ser_r,
  input  logic         ser_l,
  output logic [W-1:0] nxt
);
  // Per-bit neighbour wiring; the end bits take the serial inputs.
  logic [W-1:0] from_low;
  logic [W-1:0] from_high;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign from_low[i] = ser_r;
    end else begin : g_mid_lo
      assign from_low[i] = cur[i-1];
    end
    if (i == W - 1) begin : g_last
      assign from_high[i] = ser_l;
    end else begin : g_mid_hi
      assign from_high[i] = cur[i+1];
    end
  end

  always_comb begin
    case (mode)
      M_SHR:   nxt = from_low;
      M_SHL:   nxt = from_high;
      M_LOAD:  nxt = load_val;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ushr_drive_ctl.sv
module ushr_drive_ctl
  import ushr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dis_a,
  input  logic       dis_b,
  input  ushr_mode_e mode,
  output logic       drive_en
);
  assign drive_en = !dis_a && !dis_b && (mode != M_LOAD);

  // R6: any disable source forces the drivers off
  a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a || dis_b || mode == M_LOAD) |-> !drive_en);
  // R6: with no disable source the drivers are on
  a_r6_on_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_a && !dis_b && mode != M_LOAD) |-> drive_en);
endmodule

// File: rtl/ushr_bits.sv
module ushr_bits #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ushr_bidir.sv
module ushr_bidir
  import ushr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         ser_right_in,
  input  logic         ser_left_in,
  input  logic         dis_a,
  input  logic         dis_b,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic         pad_oe,
  output logic         tail_lsb,
  output logic         tail_msb
);
  localparam int MSB = W - 1;

  ushr_mode_e   mode_e;
  logic [W-1:0] cur_q;
  logic [W-1:0] nxt_d;

  assign mode_e = ushr_mode_e'(mode);

  ushr_next #(.W(W)) u_next (
    .cur(cur_q), .load_val(pad_in), .mode(mode_e),
    .ser_r(ser_right_in), .ser_l(ser_left_in), .nxt(nxt_d)
  );

  ushr_bits #(.W(W)) u_bits (
    .clk(clk), .rst_n(rst_n), .d(nxt_d), .q(cur_q)
  );

  ushr_drive_ctl u_drive (
    .clk(clk), .rst_n(rst_n), .dis_a(dis_a), .dis_b(dis_b),
    .mode(mode_e), .drive_en(pad_oe)
  );

  assign pad_out  = cur_q;
  assign tail_lsb = cur_q[0];
  assign tail_msb = cur_q[MSB];

  // R2: hold keeps the word
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> $stable(pad_out));
  // R3: right shift moves data up, ser_right_in enters bit 0
  a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> pad_out == {$past(pad_out[MSB-1:0]), $past(ser_right_in)});
  // R4: left shift moves data down, ser_left_in enters bit W-1
  a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> pad_out == {$past(ser_left_in), $past(pad_out[MSB:1])});
  // R5, R7: load takes pad_in whatever the disables are
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> pad_out == $past(pad_in));
  // R8: serial outputs track the end bits
  a_r8_tails: assert property (@(posedge clk) disable iff (!rst_n)
    tail_lsb == pad_out[0] && tail_msb == pad_out[MSB]);
  // R1: clocked while reset is low, the word reads zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> pad_out == '0);
endmodule

// File: tb/test_ushr_bidir.sv
module test_ushr_bidir;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sr = 1'b0, sl = 1'b0, da = 1'b0, db = 1'b0;
  logic [W-1:0] pin = '0;
  logic [W-1:0] pout;
  logic poe, tlsb, tmsb;

  // cascade pair
  logic [1:0] c_mode = 2'b00;
  logic c_sr = 1'b0, c_sl = 1'b0;
  logic [W-1:0] c_pin_lo = '0, c_pin_hi = '0;
  logic [W-1:0] lo_out, hi_out;
  logic lo_oe, hi_oe, lo_lsb, lo_msb, hi_lsb, hi_msb;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;  // 50 MHz

  ushr_bidir #(.W(W)) i_ushr_bidir (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_right_in(sr), .ser_left_in(sl),
    .dis_a(da), .dis_b(db), .pad_in(pin), .pad_out(pout), .pad_oe(poe),
    .tail_lsb(tlsb), .tail_msb(tmsb)
  );

  ushr_bidir #(.W(W)) i_lo (
    .clk(clk), .rst_n(rst_n), .mode(c_mode), .ser_right_in(c_sr), .ser_left_in(hi_lsb),
    .dis_a(1'b0), .dis_b(1'b0), .pad_in(c_pin_lo), .pad_out(lo_out), .pad_oe(lo_oe),
    .tail_lsb(lo_lsb), .tail_msb(lo_msb)
  );

  ushr_bidir #(.W(W)) i_hi (
    .clk(clk), .rst_n(rst_n), .mode(c_mode), .ser_right_in(lo_msb), .ser_left_in(c_sl),
    .dis_a(1'b0), .dis_b(1'b0), .pad_in(c_pin_hi), .pad_out(hi_out), .pad_oe(hi_oe),
    .tail_lsb(hi_lsb), .tail_msb(hi_msb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
    exp_q = '0;
    chk("R1 reset word", pout, 0);
    chk("R8 reset tails", {tmsb, tlsb}, 0);
    chk("R6 oe after reset", poe, 1);
  endtask

  task automatic t_load();
    mode = 2'b11; pin = 8'hC3;
    #1 chk("R6 oe off in load", poe, 0);
    step();
    exp_q = 8'hC3;
    chk("R5 load", pout, exp_q);
  endtask

  task automatic t_hold();
    mode = 2'b00; pin = 8'h00; sr = 1'b1; sl = 1'b1;
    repeat (3) step();
    chk("R2 hold", pout, exp_q);
    chk("R6 oe in hold", poe, 1);
  endtask

  task automatic t_shift_right();
    mode = 2'b01;
    for (int k = 0; k < 5; k++) begin
      sr = k[0];
      step();
      exp_q = {exp_q[W-2:0], k[0]};
      chk("R3 shift right", pout, exp_q);
      chk("R8 tails right", {tmsb, tlsb}, {exp_q[W-1], exp_q[0]});
    end
  endtask

  task automatic t_shift_left();
    mode = 2'b10;
    for (int k = 0; k < 5; k++) begin
      sl = ~k[0];
      step();
      exp_q = {~k[0], exp_q[W-1:1]};
      chk("R4 shift left", pout, exp_q);
      chk("R8 tails left", {tmsb, tlsb}, {exp_q[W-1], exp_q[0]});
    end
  endtask

  task automatic t_oe();
    mode = 2'b00;
    da = 1'b1; db = 1'b0; #1 chk("R6 dis_a", poe, 0);
    da = 1'b0; db = 1'b1; #1 chk("R6 dis_b", poe, 0);
    da = 1'b1; db = 1'b1; #1 chk("R6 both", poe, 0);
    da = 1'b0; db = 1'b0; #1 chk("R6 free", poe, 1);
    step();
  endtask

  task automatic t_disabled_ops();
    da = 1'b1; mode = 2'b11; pin = 8'h5A;
    step();
    exp_q = 8'h5A;
    chk("R7 load while disabled", pout, exp_q);
    chk("R8 tails while disabled", {tmsb, tlsb}, {exp_q[W-1], exp_q[0]});
    db = 1'b1; mode = 2'b01; sr = 1'b1;
    step();
    exp_q = {exp_q[W-2:0], 1'b1};
    chk("R7 shift while disabled", pout, exp_q);
    chk("R6 oe off while disabled", poe, 0);
    da = 1'b0; db = 1'b0; mode = 2'b00;
    step();
    chk("R7 word after enable", pout, exp_q);
    chk("R6 oe back on", poe, 1);
  endtask

  task automatic t_async_reset();
    mode = 2'b00;
    @(posedge clk);
    #4 rst_n = 1'b0;
    #1 chk("R1 async clear before edge", pout, 0);
    chk("R1 async tails", {tmsb, tlsb}, 0);
    @(negedge clk);
    mode = 2'b11; pin = 8'hFF;
    step();
    chk("R1 reset overrides load", pout, 0);
    rst_n = 1'b1; mode = 2'b00;
    step();
    exp_q = '0;
  endtask

  task automatic t_cascade();
    logic [2*W-1:0] e;
    c_mode = 2'b11; c_pin_lo = 8'hA5; c_pin_hi = 8'h3C;
    step();
    e = {8'h3C, 8'hA5};
    chk("R9 cascade load", {hi_out, lo_out}, e);
    c_mode = 2'b01; c_sr = 1'b1;
    step();
    e = {e[2*W-2:0], 1'b1};
    chk("R9 cascade right", {hi_out, lo_out}, e);
    c_sr = 1'b0;
    step();
    e = {e[2*W-2:0], 1'b0};
    chk("R9 cascade right 2", {hi_out, lo_out}, e);
    c_mode = 2'b10; c_sl = 1'b1;
    step();
    e = {1'b1, e[2*W-1:1]};
    chk("R9 cascade left", {hi_out, lo_out}, e);
    c_mode = 2'b00;
    step();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_shift_right();
    t_shift_left();
    t_oe();
    t_disabled_ops();
    t_async_reset();
    t_cascade();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule